// File: doc/BRIEF.md
# Priority-Decoded Multifunction Register

This block is a clocked storage word of parameterised width (four bits by default). It performs one of five actions on every rising clock edge: keep its value, take a parallel word, move one place toward the most significant end, fill with zeros or fill with ones. Four request lines choose the action. When more than one line is high, a fixed priority picks the winner: zero-fill first, then one-fill, then parallel take, then the left move. With no request high, the word holds.

Inside, a small decoder folds the four requests into a 3-bit operation code (000 hold, 001 take, 010 move left, 011 zero-fill, 100 one-fill). A per-bit selector in front of each flip-flop reads that code, and any code the decoder never produces (101, 110, 111) also keeps the bit. On a left move, each bit takes the bit just below it, bit 0 takes a separate serial input and the old top bit is lost. A synchronous active-low reset clears the word, and is intended for bring-up and test.

Top module: `mfunc_reg`

## Requirements
- R1: While rst_n is low at a rising clock edge, q becomes all zeros at that edge, whatever the request lines and data are.
- R2: When clear_req is high at a rising edge (rst_n high), q becomes all zeros at that edge, regardless of fill_req, load_req and shift_req.
- R3: When fill_req is high and clear_req is low at a rising edge, q becomes all ones at that edge, regardless of load_req and shift_req.
- R4: When load_req is high and clear_req and fill_req are low at a rising edge, q becomes din at that edge, regardless of shift_req.
- R5: When shift_req is the only request high at a rising edge, bit n of q takes the former bit n-1 for n from 1 to WIDTH-1, bit 0 takes shift_in, and the former top bit is discarded.
- R6: When no request line is high at a rising edge, q keeps its value; din and shift_in have no effect.
- R7: Across all sixteen combinations of clear_req, fill_req, load_req and shift_req, the resulting q equals the action of the highest-priority request that is high, in the order clear_req, fill_req, load_req, shift_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every action happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears q |
| clear_req | input | 1 | Request: fill with zeros (highest priority) |
| fill_req | input | 1 | Request: fill with ones |
| load_req | input | 1 | Request: take din |
| shift_req | input | 1 | Request: move one place toward the top bit (lowest priority) |
| shift_in | input | 1 | Serial bit entering bit 0 on a left move |
| din | input | WIDTH | Parallel data word |
| q | output | WIDTH | Stored word |

## Verification
Every result of this block is due at the first rising edge after the request is presented: one register lies between the request lines and q, and nothing else. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and reads q one nanosecond after that edge, so each check sees the effect of exactly one action. The sixteen-entry request table starts each entry from a freshly taken seed word, so the value read back is the result of that one combination alone. Hold checks look at q over several edges while din and shift_in are toggled.

// File: rtl/mfunc_reg_pkg.sv
// Package mfunc_reg_pkg
// Shared operation codes for the multifunction register. The decoder
// produces only the five named codes; the bit selector treats every other
// code as hold.
package mfunc_reg_pkg;

    localparam int OP_W = 3;

    typedef logic [OP_W-1:0] op_code_t;

    localparam op_code_t OP_HOLD  = 3'b000;
    localparam op_code_t OP_LOAD  = 3'b001;
    localparam op_code_t OP_SHL   = 3'b010;
    localparam op_code_t OP_CLEAR = 3'b011;
    localparam op_code_t OP_FILL  = 3'b100;

endpackage

// File: rtl/mfunc_reg_ctrl.sv
// Module mfunc_reg_ctrl
// Folds the four request lines into one operation code by fixed priority:
// clear over fill, fill over load, load over left move; nothing high means
// hold. Purely combinational; assumes inputs are settled before the edge.
module mfunc_reg_ctrl
    import mfunc_reg_pkg::*;
(
    input  logic     clear_req,
    input  logic     fill_req,
    input  logic     load_req,
    input  logic     shift_req,
    output op_code_t op_code
);

    // Select-bit equations of the priority mapping.
    always_comb begin
        op_code[2] = !clear_req & fill_req;
        op_code[1] = clear_req | (!clear_req & !fill_req & !load_req & shift_req);
        op_code[0] = clear_req | (!clear_req & !fill_req & load_req);
    end

    // R7: the decoder must never emit one of the spare codes.
    always_comb begin
        if (!$isunknown({clear_req, fill_req, load_req, shift_req})) begin
            a_r7_legal_code: assert (op_code <= OP_FILL)
                else $error("decoder produced spare code %b", op_code);
        end
    end

endmodule

// File: rtl/mfunc_reg_cell.sv
// Module mfunc_reg_cell
// Next-state selector for one stored bit. Picks between the bit's own
// value, the parallel bit, the bit below, constant zero and constant one.
// Spare operation codes keep the bit unchanged.
module mfunc_reg_cell
    import mfunc_reg_pkg::*;
(
    input  op_code_t op_code,
    input  logic     cur_bit,
    input  logic     par_bit,
    input  logic     below_bit,
    output logic     next_bit
);

    // Per-bit multiplexer driven by the operation code.
    always_comb begin
        case (op_code)
            OP_LOAD:  next_bit = par_bit;
            OP_SHL:   next_bit = below_bit;
            OP_CLEAR: next_bit = 1'b0;
            OP_FILL:  next_bit = 1'b1;
            default:  next_bit = cur_bit;
        endcase
    end

endmodule

// File: rtl/mfunc_reg.sv
// Module mfunc_reg
// Multifunction register: hold, parallel take, left move with serial
// entry, zero-fill and one-fill, chosen by prioritised request lines.
// Assumes WIDTH >= 2. Reset is synchronous and active low.
module mfunc_reg
    import mfunc_reg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_req,
    input  logic             fill_req,
    input  logic             load_req,
    input  logic             shift_req,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    localparam int TOP = WIDTH - 1;

    op_code_t         op_code;
    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] q_next;

    mfunc_reg_ctrl u_ctrl (
        .clear_req (clear_req),
        .fill_req  (fill_req),
        .load_req  (load_req),
        .shift_req (shift_req),
        .op_code   (op_code)
    );

    // One selector per bit; bit 0 takes the serial input on a left move.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            mfunc_reg_cell u_cell (
                .op_code   (op_code),
                .cur_bit   (q_r[i]),
                .par_bit   (din[i]),
                .below_bit (shift_in),
                .next_bit  (q_next[i])
            );
        end else begin : g_upper
            mfunc_reg_cell u_cell (
                .op_code   (op_code),
                .cur_bit   (q_r[i]),
                .par_bit   (din[i]),
                .below_bit (q_r[i-1]),
                .next_bit  (q_next[i])
            );
        end
    end

    // Storage flip-flops with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_next;
    end

    assign q = q_r;

    // R1: reset clears the word at the next edge.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R2: zero-fill wins over every other request.
    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (q == '0));

    // R3: one-fill when clear is absent.
    a_r3_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_req && fill_req) |=> (q == {WIDTH{1'b1}}));

    // R4: parallel take when clear and fill are absent.
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_req && !fill_req && load_req) |=> (q == $past(din)));

    // R5: left move with serial entry at bit 0.
    a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_req && !fill_req && !load_req && shift_req)
        |=> (q == {$past(q[TOP-1:0]), $past(shift_in)}));

    // R6: no request keeps the word.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_req && !fill_req && !load_req && !shift_req) |=> $stable(q));

endmodule

// File: tb/tb_mfunc_reg.sv
// Bench for mfunc_reg: a request table walked by one loop, then directed
// tests for reset, left-move chains, hold and parallel take.
module tb_mfunc_reg;

    localparam int W = 4;
    localparam logic [W-1:0] SEED   = 4'b1010;
    localparam logic [W-1:0] TBL_DIN = 4'b0110;
    localparam logic         TBL_SIN = 1'b1;

    // Entry: {clear, fill, load, shift, expected q} from SEED with TBL_DIN, TBL_SIN.
    localparam logic [7:0] TBL [16] = '{
        {4'b0000, 4'b1010}, {4'b0001, 4'b0101}, {4'b0010, 4'b0110}, {4'b0011, 4'b0110},
        {4'b0100, 4'b1111}, {4'b0101, 4'b1111}, {4'b0110, 4'b1111}, {4'b0111, 4'b1111},
        {4'b1000, 4'b0000}, {4'b1001, 4'b0000}, {4'b1010, 4'b0000}, {4'b1011, 4'b0000},
        {4'b1100, 4'b0000}, {4'b1101, 4'b0000}, {4'b1110, 4'b0000}, {4'b1111, 4'b0000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clear_req = 1'b0, fill_req = 1'b0, load_req = 1'b0, shift_req = 1'b0;
    logic         shift_in = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;

    int checks = 0;
    int errors = 0;

    mfunc_reg #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .clear_req(clear_req), .fill_req(fill_req),
        .load_req(load_req), .shift_req(shift_req), .shift_in(shift_in),
        .din(din), .q(q)
    );

    always #4 clk = ~clk;

    // Reference model of one action with the stated priority.
    function automatic logic [W-1:0] model(input logic [3:0] ctl, input logic [W-1:0] cur,
                                           input logic [W-1:0] d, input logic si);
        if (ctl[3])      return '0;
        else if (ctl[2]) return '1;
        else if (ctl[1]) return d;
        else if (ctl[0]) return {cur[W-2:0], si};
        else             return cur;
    endfunction

    task automatic check(input string req, input logic [W-1:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected=%b", req, q, exp);
        end
    endtask

    // Present inputs at the falling edge, pass one rising edge, sample 1 ns later.
    task automatic step(input logic rn, input logic [3:0] ctl, input logic [W-1:0] d,
                        input logic si);
        @(negedge clk);
        rst_n = rn;
        {clear_req, fill_req, load_req, shift_req} = ctl;
        din = d;
        shift_in = si;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: q=%b expected=completion", q);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] exp;
        // R1: reset with every request high and nonzero data.
        step(1'b0, 4'b1111, 4'b1111, 1'b1);
        check("R1 reset with requests", '0);
        step(1'b0, 4'b0110, 4'b1011, 1'b1);
        check("R1 reset over fill/load", '0);

        // R7: every request combination from a fresh seed.
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 4'b0010, SEED, 1'b0);
            check("R4 seed load", SEED);
            step(1'b1, TBL[i][7:4], TBL_DIN, TBL_SIN);
            check($sformatf("R7 combo %b", TBL[i][7:4]), TBL[i][3:0]);
            if (model(TBL[i][7:4], SEED, TBL_DIN, TBL_SIN) !== TBL[i][3:0]) begin
                checks++;
                errors++;
                $display("FAIL R7 table/model mismatch: q=%b expected=%b", TBL[i][3:0],
                         model(TBL[i][7:4], SEED, TBL_DIN, TBL_SIN));
            end
        end

        // R5: chain of left moves, serial pattern 1,1,0,1 then zeros; top bit dropped.
        step(1'b1, 4'b0010, 4'b1001, 1'b0);
        check("R4 load 1001", 4'b1001);
        exp = 4'b1001;
        for (int k = 0; k < 6; k++) begin
            logic si;
            si = (k < 4) ? ((4'b1011 >> k) & 1'b1) : 1'b0;
            step(1'b1, 4'b0001, 4'b1111, si);
            exp = {exp[W-2:0], si};
            check($sformatf("R5 shift %0d", k), exp);
        end

        // R6: hold over several edges while data and serial input toggle.
        step(1'b1, 4'b0010, 4'b0101, 1'b0);
        check("R4 load 0101", 4'b0101);
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 4'b0000, ~din, ~shift_in);
            check($sformatf("R6 hold %0d", k), 4'b0101);
        end

        // R2 / R3 directed: clear over fill, fill then hold, clear over shift.
        step(1'b1, 4'b1100, 4'b0101, 1'b1);
        check("R2 clear over fill", 4'b0000);
        step(1'b1, 4'b0111, 4'b0000, 1'b0);
        check("R3 fill over load/shift", 4'b1111);
        step(1'b1, 4'b1001, 4'b0000, 1'b1);
        check("R2 clear over shift", 4'b0000);

        // R4: load wins over shift with distinct words.
        step(1'b1, 4'b0011, 4'b1100, 1'b1);
        check("R4 load over shift", 4'b1100);
        step(1'b1, 4'b0010, 4'b0011, 1'b0);
        check("R4 load 0011", 4'b0011);

        // R1: reset mid-operation, then hold keeps zero.
        step(1'b0, 4'b0100, 4'b1111, 1'b1);
        check("R1 reset mid-run", 4'b0000);
        step(1'b1, 4'b0000, 4'b1111, 1'b1);
        check("R6 hold after reset", 4'b0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule